// File: doc/BRIEF.md
# Serial CRC-4 Remainder Engine

This block forms a 4-bit cyclic redundancy remainder one bit per clock. Each step is a long-division step by a polynomial of order four. The leading coefficient of that polynomial is always 1 and is not wired. The four lower coefficients come in on a tap input, so one datapath can serve any order-4 polynomial. On every clock where the step enable is high, the remainder register moves left by one place and takes the serial bit into its lowest position. If the bit that left the top position was 1, the tap vector is then XORed into the register.

The block can act as a generator. The message goes in most significant bit first, followed by four zero bits, and the register then holds the code to transmit. It can also act as a checker. The message goes in followed by the received code, and the zero flag shows whether the remainder came out clean.

Top module: `serial_crc_engine`

## Requirements
- R1: On a rising clock edge with `rst_n` low, the remainder becomes 0000. The zero flag then reads 1.
- R2: On a rising edge with `step_en` low, the remainder keeps its value, whatever `bit_in` and `taps` carry.
- R3: On a rising edge with `step_en` high, the new remainder is the old value shifted left by one, with `bit_in` placed in bit 0. When old bit 3 was 1, `taps` is XORed into that result.
- R4: `taps[i]` is the coefficient of x^i for i = 0..3, and the x^4 coefficient is implied. The polynomial x^4+x^3+1 is therefore `taps` = 1001, and x^4+x+1 is `taps` = 0011.
- R5: When old bit 3 is 0, an enabled step is a plain shift that takes in `bit_in`. The value of `taps` has no effect on that step.
- R6: With `taps` = 1001, the first six enabled bits of the stream 111001100110 leave the remainder at 0001, 0011, 0111, 1110, 0101 and 1011, in that order.
- R7: Generator use: with `taps` = 1001, the stream 11100110 followed by 0000 leaves the remainder at 0110.
- R8: Checker use: with `taps` = 1001, the stream 111001100110 leaves the remainder at 0000 and `rem_zero` high. A stream with one bit flipped leaves `rem_zero` low.
- R9: `rem_zero` is combinational from the register. It is 1 exactly when all four remainder bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| step_en | input | 1 | Advances the remainder by one bit when high |
| bit_in | input | 1 | Serial data bit, most significant bit first |
| taps | input | 4 | Lower generator coefficients, bit i is the coefficient of x^i |
| remainder | output | 4 | Running remainder, bit 3 most significant |
| rem_zero | output | 1 | High when the remainder is 0000 |

## Verification
The bench builds the engine with its default width of four bits. This is the only order the block is meant for, so every bit position and every path through the feedback gating can be observed directly. Two tap vectors are used: 1001, which gives the worked generator and checker streams, and 0011, which runs against a bit-level long-division model on several messages. A tap vector of 1111 applied while the enable is low shows that held steps ignore `taps`.

// File: rtl/crc_pkg.sv
// Package: shared sizing for the serial CRC engine.
// Assumes the polynomial order equals the register width.
package crc_pkg;
    localparam int unsigned CRC_ORDER_DEFAULT = 4;
endpackage

// File: rtl/crc_next_state.sv
// Module: combinational one-bit division step.
// Shifts the remainder left, inserts the serial bit, and folds the
// lower generator taps in when the outgoing top bit is 1.
// Assumes the leading coefficient is an implicit 1.
module crc_next_state #(
    parameter int unsigned W = crc_pkg::CRC_ORDER_DEFAULT
) (
    input  logic [W-1:0] cur_rem,
    input  logic         ser_bit,
    input  logic [W-1:0] gen_taps,
    output logic [W-1:0] nxt_rem
);
    localparam int unsigned TOP = W - 1;

    logic carry_out;

    // Purpose: the bit leaving the register decides whether to subtract.
    always_comb carry_out = cur_rem[TOP];

    // Purpose: bit 0 takes the serial input, corrected by tap 0.
    always_comb nxt_rem[0] = ser_bit ^ (carry_out & gen_taps[0]);

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_stage
            // Purpose: each upper stage takes its neighbour, corrected by its tap.
            always_comb nxt_rem[gi] = cur_rem[gi-1] ^ (carry_out & gen_taps[gi]);
        end
    endgenerate
endmodule

// File: rtl/crc_rem_reg.sv
// Module: remainder storage with synchronous active-low clear and
// a step enable. Holds its value whenever the enable is low.
module crc_rem_reg #(
    parameter int unsigned W = crc_pkg::CRC_ORDER_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    // Purpose: clear on reset, capture the next remainder on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_out <= '0;
        else if (load_en)
            q_out <= d_in;
    end

    // R2: a held edge leaves the stored value untouched
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(q_out));

    // R1: a clear edge always leaves zero behind
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (q_out == '0));
endmodule

// File: rtl/crc_zero_detect.sv
// Module: all-zero detector for the remainder, used as the checker pass flag.
module crc_zero_detect #(
    parameter int unsigned W = crc_pkg::CRC_ORDER_DEFAULT
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    // Purpose: reduce the remainder to one pass/fail bit.
    always_comb is_zero = ~(|value);
endmodule

// File: rtl/serial_crc_engine.sv
// Module: serial CRC remainder engine (top).
// One bit per enabled clock, with a runtime order-W polynomial whose
// leading coefficient is implied. It serves as a generator (message
// then W zeros) or as a checker (message then received code).
module serial_crc_engine #(
    parameter int unsigned W = crc_pkg::CRC_ORDER_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         bit_in,
    input  logic [W-1:0] taps,
    output logic [W-1:0] remainder,
    output logic         rem_zero
);
    logic [W-1:0] next_rem;

    crc_next_state #(.W(W)) step_i (
        .cur_rem  (remainder),
        .ser_bit  (bit_in),
        .gen_taps (taps),
        .nxt_rem  (next_rem)
    );

    crc_rem_reg #(.W(W)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (step_en),
        .d_in    (next_rem),
        .q_out   (remainder)
    );

    crc_zero_detect #(.W(W)) zero_i (
        .value   (remainder),
        .is_zero (rem_zero)
    );

    // R5: no outgoing 1 means a plain shift, whatever the taps say
    assert_plain_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !remainder[W-1]) |=>
            (remainder == {$past(remainder[W-2:0]), $past(bit_in)}));

    // R3: an outgoing 1 with all taps clear drops the top bit and nothing else
    assert_empty_taps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && remainder[W-1] && (taps == '0)) |=>
            (remainder == {$past(remainder[W-2:0]), $past(bit_in)}));

    // R9: the pass flag agrees with the register contents
    assert_flag_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rem_zero |-> ($countones(remainder) == 0));
endmodule

// File: tb/serial_crc_engine_tb_top.sv
// Directed bench for the serial CRC engine, one task per scenario.
module serial_crc_engine_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic         bit_in = 1'b0;
    logic [W-1:0] taps = '0;
    logic [W-1:0] remainder;
    logic         rem_zero;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serial_crc_engine #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .bit_in(bit_in),
        .taps(taps), .remainder(remainder), .rem_zero(rem_zero)
    );

    // Reference step, written from the requirement text (R3).
    function automatic logic [W-1:0] ref_step(logic [W-1:0] r, logic b, logic [W-1:0] g);
        logic [W-1:0] s;
        s = {r[W-2:0], b};
        if (r[W-1]) s = s ^ g;
        return s;
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge and sample just after the rising edge.
    task automatic cycle(logic en, logic b);
        @(negedge clk);
        step_en = en;
        bit_in  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step_en = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge clk); rst_n = 1'b1; step_en = 1'b1; bit_in = 1'b1; taps = 4'b1001;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 clear", remainder, 4'b0000);
        check("R1 flag", {3'b0, rem_zero}, 4'b0001);
        @(negedge clk); rst_n = 1'b1; step_en = 1'b0;
    endtask

    task automatic t_example_trace();
        logic [11:0] s = 12'b111001100110;
        logic [W-1:0] exp_seq [6] = '{4'b0001, 4'b0011, 4'b0111, 4'b1110, 4'b0101, 4'b1011};
        do_reset();
        taps = 4'b1001;
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, s[11-i]);
            check("R6 trace", remainder, exp_seq[i]);
        end
    endtask

    task automatic t_generator();
        logic [11:0] s = 12'b111001100000;
        do_reset();
        taps = 4'b1001;
        for (int i = 0; i < 12; i++) cycle(1'b1, s[11-i]);
        check("R7 code", remainder, 4'b0110);
        check("R9 flag low", {3'b0, rem_zero}, 4'b0000);
    endtask

    task automatic t_checker();
        logic [11:0] s = 12'b111001100110;
        do_reset();
        taps = 4'b1001;
        for (int i = 0; i < 12; i++) cycle(1'b1, s[11-i]);
        check("R8 clean rem", remainder, 4'b0000);
        check("R8 clean flag", {3'b0, rem_zero}, 4'b0001);
        s = 12'b111011100110;
        do_reset();
        for (int i = 0; i < 12; i++) cycle(1'b1, s[11-i]);
        check("R8 corrupt flag", {3'b0, rem_zero}, 4'b0000);
    endtask

    task automatic t_hold();
        logic [W-1:0] snap;
        do_reset();
        taps = 4'b1001;
        cycle(1'b1, 1'b1); cycle(1'b1, 1'b1); cycle(1'b1, 1'b1); cycle(1'b1, 1'b0);
        snap = remainder;
        taps = 4'b1111;
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, i[0]);
            check("R2 hold", remainder, snap);
        end
        taps = 4'b1001;
        cycle(1'b1, 1'b0);
        check("R3 resume", remainder, ref_step(snap, 1'b0, 4'b1001));
    endtask

    task automatic t_plain_shift();
        do_reset();
        taps = 4'b1111;
        cycle(1'b1, 1'b1);
        check("R5 shift 1", remainder, 4'b0001);
        cycle(1'b1, 1'b0);
        check("R5 shift 2", remainder, 4'b0010);
        cycle(1'b1, 1'b1);
        check("R5 shift 3", remainder, 4'b0101);
        cycle(1'b1, 1'b0);
        check("R3 fold 1111", remainder, 4'b1010 ^ 4'b0000);
        cycle(1'b1, 1'b1);
        check("R3 fold taps", remainder, 4'b0101 ^ 4'b1111);
    endtask

    task automatic t_other_poly();
        logic [15:0] msgs [3] = '{16'hA5C3, 16'h0001, 16'hFFFF};
        logic [W-1:0] model;
        for (int m = 0; m < 3; m++) begin
            do_reset();
            taps = 4'b0011;   // R4: x^4 + x + 1
            model = '0;
            for (int i = 0; i < 20; i++) begin
                logic b;
                b = (i < 16) ? msgs[m][15-i] : 1'b0;
                cycle(1'b1, b);
                model = ref_step(model, b, 4'b0011);
            end
            check("R4 poly 0011", remainder, model);
        end
    endtask

    initial begin
        t_reset_state();
        t_example_trace();
        t_generator();
        t_checker();
        t_hold();
        t_plain_shift();
        t_other_poly();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule